// File: doc/BRIEF.md
# Width-Converting I/O Clock-Crossing FIFO

This block is a shallow dual-clock FIFO that sits between a physical-layer I/O logic block and the general fabric. It carries several parallel lanes across two unrelated clocks. All lanes share one pair of pointers. Each array entry holds one byte per lane.

The I/O-logic side always moves one nibble per lane per access. The fabric side moves either a nibble or a byte per lane, chosen by the `wide` input. In byte mode the block acts as a 2:1 converter, so the fabric can run at half the I/O word rate.

A parameter picks the direction:
- **Inbound:** nibbles are written. In byte mode two nibbles are packed into one entry, with the earlier nibble in the low half.
- **Outbound:** bytes are written. In byte mode each entry is read back as two nibbles, low half first.

Pointers cross the clock boundary as Gray code through two-flop synchronizers. The array holds 2^ADDR_W entries. With the default ADDR_W = 3 that is eight array entries, and together with the read output register the block holds nine words. A packing stage on the write side adds room for one pending nibble in inbound byte mode. `wide` is expected to change only while reset is held.

Top module: `iofifo_bridge`

## Requirements
- R1: While `rst_n` is low, `empty` is 1 and `full` is 0. Reset discards all stored entries, any pending packing nibble and any half-read unpack state, and clears `rd_data` to zero.
- R2: Inbound with `wide`=0: each written nibble vector is read back once, in write order. Lane i's nibble appears in bits [8i+3:8i] of `rd_data`, and bits [8i+7:8i+4] read as zero.
- R3: Inbound with `wide`=1: two accepted writes form one entry, and a lone first nibble is never readable. Lane i's byte at [8i+7:8i] carries the earlier nibble in bits [3:0] and the later nibble in bits [7:4].
- R4: Outbound with `wide`=0: each written byte vector yields one read. Lane i's `rd_data` bits [4i+3:4i] equal bits [8i+3:8i] of the written data, and the upper nibble of each written byte has no effect.
- R5: Outbound with `wide`=1: each written byte vector yields two reads, first the low nibble of each lane, then the high nibble. `empty` stays 0 between the two reads.
- R6: `full` is 1 when the array holds 2^ADDR_W entries. In inbound byte mode it is 1 only when, in addition, a first nibble is already staged.
- R7: A write while `full` is 1 is dropped. No entry is added and none is overwritten.
- R8: A read while `empty` is 1 is dropped. No pointer moves and `rd_data` keeps its value.
- R9: Data for an accepted read appears on `rd_data` after the next `rd_clk` edge. It then holds until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wide | input | 1 | 1 = byte per lane on the fabric side (2:1 mode), 0 = nibble per lane |
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write request |
| wr_data | input | LANES*4 inbound, LANES*8 outbound | Write data, lane i in its own nibble or byte slot |
| full | output | 1 | Write side cannot accept data |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read request |
| rd_data | output | LANES*8 inbound, LANES*4 outbound | Registered read data |
| empty | output | 1 | Nothing readable |

## Verification
The bench builds two copies side by side, one inbound and one outbound, each with LANES = 3 and ADDR_W = 2. Four array entries make full and the dropped-write path reachable after only a handful of writes. Three lanes, each given a different value, expose any swapped or shared lane slice. Because the two clocks have unrelated periods, both synchronizer paths see varying phase. The pending-nibble corner of inbound byte mode is covered by filling the array and then staging one extra nibble.

// File: rtl/iofifo_pkg.sv
package iofifo_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;

    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } half_e;

endpackage

// File: rtl/iofifo_sync.sv
module iofifo_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d        = sy_q;
        sy_d.meta   = din;
        sy_d.stable = sy_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign dout = sy_q.stable;

endmodule

// File: rtl/iofifo_mem.sv
module iofifo_mem #(
    parameter int ADDR_W = 3,
    parameter int ENT_W  = 96,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ENT_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [ENT_W-1:0]  rdata
);

    logic [ENT_W-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/iofifo_wr.sv
module iofifo_wr
    import iofifo_pkg::*;
#(
    parameter int LANES    = 12,
    parameter int ADDR_W   = 3,
    parameter bit OUTBOUND = 1'b0,
    localparam int PTR_W   = ADDR_W + 1,
    localparam int DEPTH   = 1 << ADDR_W,
    localparam int ENT_W   = LANES * BYTE_W,
    localparam int NIBS_W  = LANES * NIB_W,
    localparam int WR_W    = OUTBOUND ? ENT_W : NIBS_W
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic              wide,
    input  logic              wr_en,
    input  logic [WR_W-1:0]   wr_data,
    input  logic [PTR_W-1:0]  rgray_sync,
    output logic              full,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [ENT_W-1:0]  mem_wdata,
    output logic [PTR_W-1:0]  wgray
);

    localparam logic [PTR_W-1:0] WRAP_MASK = {2'b11, {(PTR_W-2){1'b0}}};

    typedef struct packed {
        logic [PTR_W-1:0]  bin;
        logic [PTR_W-1:0]  gray;
        logic [NIBS_W-1:0] stage;
        half_e             half;
    } wr_state_t;

    wr_state_t st_d, st_q;

    logic [ENT_W-1:0]  narrow_ent;
    logic [ENT_W-1:0]  pair_ent;
    logic [ENT_W-1:0]  byte_ent;
    logic [NIBS_W-1:0] nib_in;
    logic              arr_full;
    logic              full_c;
    logic              accept;
    logic              push;
    logic [ENT_W-1:0]  ent;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (OUTBOUND) begin : g_ob
            assign narrow_ent[BYTE_W*l +: BYTE_W] = {4'h0, wr_data[BYTE_W*l +: NIB_W]};
            assign nib_in[NIB_W*l +: NIB_W]       = 4'h0;
        end else begin : g_ib
            assign narrow_ent[BYTE_W*l +: BYTE_W] = {4'h0, wr_data[NIB_W*l +: NIB_W]};
            assign nib_in[NIB_W*l +: NIB_W]       = wr_data[NIB_W*l +: NIB_W];
        end
        assign pair_ent[BYTE_W*l +: BYTE_W] = {nib_in[NIB_W*l +: NIB_W], st_q.stage[NIB_W*l +: NIB_W]};
    end

    if (OUTBOUND) begin : g_byte_ob
        assign byte_ent = wr_data;
    end else begin : g_byte_ib
        assign byte_ent = pair_ent;
    end

    always_comb begin
        st_d     = st_q;
        push     = 1'b0;
        ent      = narrow_ent;
        arr_full = (st_q.gray == (rgray_sync ^ WRAP_MASK));
        if (!OUTBOUND && wide) full_c = arr_full && (st_q.half == HALF_HIGH);
        else                   full_c = arr_full;
        accept = wr_en && !full_c;
        if (accept) begin
            if (!wide) begin
                push = 1'b1;
                ent  = narrow_ent;
            end else if (OUTBOUND) begin
                push = 1'b1;
                ent  = byte_ent;
            end else if (st_q.half == HALF_LOW) begin
                st_d.stage = nib_in;
                st_d.half  = HALF_HIGH;
            end else begin
                push      = 1'b1;
                ent       = byte_ent;
                st_d.half = HALF_LOW;
            end
        end
        if (push) begin
            st_d.bin  = st_q.bin + 1'b1;
            st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        end
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bin: '0, gray: '0, stage: '0, half: HALF_LOW};
        else        st_q <= st_d;
    end

    assign full      = full_c;
    assign mem_we    = push;
    assign mem_waddr = st_q.bin[ADDR_W-1:0];
    assign mem_wdata = ent;
    assign wgray     = st_q.gray;

    function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (PTR_W'(st_q.bin - g2b(rgray_sync)) <= PTR_W'(DEPTH))); // R6
    AST_FULL_WRITE_DROPPED: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (full && wr_en) |=> ($stable(st_q.bin) && $stable(st_q.half))); // R7
    AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $onehot0(st_q.gray ^ $past(st_q.gray))); // R6

endmodule

// File: rtl/iofifo_rd.sv
module iofifo_rd
    import iofifo_pkg::*;
#(
    parameter int LANES    = 12,
    parameter int ADDR_W   = 3,
    parameter bit OUTBOUND = 1'b0,
    localparam int PTR_W   = ADDR_W + 1,
    localparam int DEPTH   = 1 << ADDR_W,
    localparam int ENT_W   = LANES * BYTE_W,
    localparam int NIBS_W  = LANES * NIB_W,
    localparam int RD_W    = OUTBOUND ? NIBS_W : ENT_W
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wide,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  wgray_sync,
    input  logic [ENT_W-1:0]  mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [PTR_W-1:0]  rgray,
    output logic [RD_W-1:0]   rd_data,
    output logic              empty
);

    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
        half_e            sel;
        logic [RD_W-1:0]  dout;
    } rd_state_t;

    rd_state_t st_d, st_q;

    logic [RD_W-1:0] out_a;
    logic [RD_W-1:0] out_b;
    logic            empty_c;
    logic            accept;
    logic            pop;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (OUTBOUND) begin : g_ob
            assign out_a[NIB_W*l +: NIB_W] = mem_rdata[BYTE_W*l +: NIB_W];
            assign out_b[NIB_W*l +: NIB_W] = mem_rdata[BYTE_W*l + NIB_W +: NIB_W];
        end else begin : g_ib
            assign out_a[BYTE_W*l +: BYTE_W] = {4'h0, mem_rdata[BYTE_W*l +: NIB_W]};
            assign out_b[BYTE_W*l +: BYTE_W] = mem_rdata[BYTE_W*l +: BYTE_W];
        end
    end

    always_comb begin
        st_d    = st_q;
        pop     = 1'b0;
        empty_c = (st_q.gray == wgray_sync);
        accept  = rd_en && !empty_c;
        if (accept) begin
            if (!wide) begin
                st_d.dout = out_a;
                pop       = 1'b1;
            end else if (!OUTBOUND) begin
                st_d.dout = out_b;
                pop       = 1'b1;
            end else if (st_q.sel == HALF_LOW) begin
                st_d.dout = out_a;
                st_d.sel  = HALF_HIGH;
            end else begin
                st_d.dout = out_b;
                st_d.sel  = HALF_LOW;
                pop       = 1'b1;
            end
        end
        if (pop) begin
            st_d.bin  = st_q.bin + 1'b1;
            st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bin: '0, gray: '0, sel: HALF_LOW, dout: '0};
        else        st_q <= st_d;
    end

    assign mem_raddr = st_q.bin[ADDR_W-1:0];
    assign rgray     = st_q.gray;
    assign rd_data   = st_q.dout;
    assign empty     = empty_c;

    function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (PTR_W'(g2b(wgray_sync) - st_q.bin) <= PTR_W'(DEPTH))); // R8
    AST_EMPTY_READ_DROPPED: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (empty && rd_en) |=> ($stable(st_q.bin) && $stable(rd_data))); // R8
    AST_DOUT_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!rd_en) |=> $stable(rd_data)); // R9
    AST_RGRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $onehot0(st_q.gray ^ $past(st_q.gray))); // R6

endmodule

// File: rtl/iofifo_bridge.sv
module iofifo_bridge
    import iofifo_pkg::*;
#(
    parameter int LANES    = 12,
    parameter int ADDR_W   = 3,
    parameter bit OUTBOUND = 1'b0,
    localparam int PTR_W   = ADDR_W + 1,
    localparam int ENT_W   = LANES * BYTE_W,
    localparam int NIBS_W  = LANES * NIB_W,
    localparam int WR_W    = OUTBOUND ? ENT_W : NIBS_W,
    localparam int RD_W    = OUTBOUND ? NIBS_W : ENT_W
) (
    input  logic            rst_n,
    input  logic            wide,
    input  logic            wr_clk,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    output logic            full,
    input  logic            rd_clk,
    input  logic            rd_en,
    output logic [RD_W-1:0] rd_data,
    output logic            empty
);

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    logic [ENT_W-1:0]  mem_wdata;
    logic [ENT_W-1:0]  mem_rdata;
    logic [PTR_W-1:0]  wgray;
    logic [PTR_W-1:0]  rgray;
    logic [PTR_W-1:0]  wgray_rs;
    logic [PTR_W-1:0]  rgray_ws;

    iofifo_wr #(.LANES(LANES), .ADDR_W(ADDR_W), .OUTBOUND(OUTBOUND)) u_wr (
        .wr_clk     (wr_clk),
        .rst_n      (rst_n),
        .wide       (wide),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rgray_sync (rgray_ws),
        .full       (full),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .wgray      (wgray)
    );

    iofifo_mem #(.ADDR_W(ADDR_W), .ENT_W(ENT_W)) u_mem (
        .wr_clk (wr_clk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (mem_wdata),
        .raddr  (mem_raddr),
        .rdata  (mem_rdata)
    );

    iofifo_sync #(.W(PTR_W)) u_sync_w2r (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .din   (wgray),
        .dout  (wgray_rs)
    );

    iofifo_sync #(.W(PTR_W)) u_sync_r2w (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .din   (rgray),
        .dout  (rgray_ws)
    );

    iofifo_rd #(.LANES(LANES), .ADDR_W(ADDR_W), .OUTBOUND(OUTBOUND)) u_rd (
        .rd_clk     (rd_clk),
        .rst_n      (rst_n),
        .wide       (wide),
        .rd_en      (rd_en),
        .wgray_sync (wgray_rs),
        .mem_rdata  (mem_rdata),
        .mem_raddr  (mem_raddr),
        .rgray      (rgray),
        .rd_data    (rd_data),
        .empty      (empty)
    );

endmodule

// File: tb/iofifo_bridge_bench.sv
`timescale 1ns/1ps
module iofifo_bridge_bench;

    localparam int LANES  = 3;
    localparam int ADDR_W = 2;
    localparam int NW     = LANES * 4;
    localparam int BW     = LANES * 8;

    logic wr_clk = 1'b0;
    logic rd_clk = 1'b0;
    logic rst_n  = 1'b0;
    logic wide   = 1'b0;

    logic          in_we = 1'b0, in_re = 1'b0;
    logic [NW-1:0] in_wd = '0;
    logic [BW-1:0] in_rd;
    logic          in_full, in_empty;

    logic          ob_we = 1'b0, ob_re = 1'b0;
    logic [BW-1:0] ob_wd = '0;
    logic [NW-1:0] ob_rd;
    logic          ob_full, ob_empty;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 wr_clk = ~wr_clk;
    always #15 rd_clk = ~rd_clk;

    iofifo_bridge #(.LANES(LANES), .ADDR_W(ADDR_W), .OUTBOUND(1'b0)) u_iofifo_bridge (
        .rst_n(rst_n), .wide(wide),
        .wr_clk(wr_clk), .wr_en(in_we), .wr_data(in_wd), .full(in_full),
        .rd_clk(rd_clk), .rd_en(in_re), .rd_data(in_rd), .empty(in_empty)
    );

    iofifo_bridge #(.LANES(LANES), .ADDR_W(ADDR_W), .OUTBOUND(1'b1)) u_iofifo_bridge_ob (
        .rst_n(rst_n), .wide(wide),
        .wr_clk(wr_clk), .wr_en(ob_we), .wr_data(ob_wd), .full(ob_full),
        .rd_clk(rd_clk), .rd_en(ob_re), .rd_data(ob_rd), .empty(ob_empty)
    );

    function automatic logic [NW-1:0] nv(input int s);
        logic [NW-1:0] r;
        for (int l = 0; l < LANES; l++) r[4*l +: 4] = 4'(s + 5 * l);
        return r;
    endfunction

    function automatic logic [BW-1:0] zx(input int s);
        logic [BW-1:0] r;
        logic [NW-1:0] n;
        n = nv(s);
        for (int l = 0; l < LANES; l++) r[8*l +: 8] = {4'h0, n[4*l +: 4]};
        return r;
    endfunction

    function automatic logic [BW-1:0] pk(input int hi, input int lo);
        logic [BW-1:0] r;
        logic [NW-1:0] h, o;
        h = nv(hi);
        o = nv(lo);
        for (int l = 0; l < LANES; l++) r[8*l +: 8] = {h[4*l +: 4], o[4*l +: 4]};
        return r;
    endfunction

    function automatic logic [BW-1:0] bv(input int s);
        logic [BW-1:0] r;
        for (int l = 0; l < LANES; l++) r[8*l +: 8] = 8'(s * 37 + 83 * l + 17);
        return r;
    endfunction

    function automatic logic [NW-1:0] lo_of(input int s);
        logic [NW-1:0] r;
        logic [BW-1:0] b;
        b = bv(s);
        for (int l = 0; l < LANES; l++) r[4*l +: 4] = b[8*l +: 4];
        return r;
    endfunction

    function automatic logic [NW-1:0] hi_of(input int s);
        logic [NW-1:0] r;
        logic [BW-1:0] b;
        b = bv(s);
        for (int l = 0; l < LANES; l++) r[4*l +: 4] = b[8*l + 4 +: 4];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge wr_clk);
        rst_n = 1'b0;
        wide  = mode;
        repeat (3) @(negedge rd_clk);
        chk("R1 in empty in reset", 32'(in_empty), 32'd1);
        chk("R1 ob empty in reset", 32'(ob_empty), 32'd1);
        @(negedge wr_clk);
        chk("R1 in full in reset", 32'(in_full), 32'd0);
        chk("R1 ob full in reset", 32'(ob_full), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge rd_clk);
    endtask

    task automatic settle();
        repeat (4) @(negedge rd_clk);
        repeat (4) @(negedge wr_clk);
    endtask

    task automatic in_write(input int s);
        @(negedge wr_clk);
        in_we = 1'b1;
        in_wd = nv(s);
        @(negedge wr_clk);
        in_we = 1'b0;
    endtask

    task automatic ob_write(input int s);
        @(negedge wr_clk);
        ob_we = 1'b1;
        ob_wd = bv(s);
        @(negedge wr_clk);
        ob_we = 1'b0;
    endtask

    task automatic in_read(input logic [BW-1:0] exp, input string req);
        @(negedge rd_clk);
        in_re = 1'b1;
        @(negedge rd_clk);
        in_re = 1'b0;
        chk(req, 32'(in_rd), 32'(exp));
    endtask

    task automatic ob_read(input logic [NW-1:0] exp, input string req);
        @(negedge rd_clk);
        ob_re = 1'b1;
        @(negedge rd_clk);
        ob_re = 1'b0;
        chk(req, 32'(ob_rd), 32'(exp));
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
        chk("R1 in rd_data after reset", 32'(in_rd), 32'd0);
        chk("R1 ob rd_data after reset", 32'(ob_rd), 32'd0);
        chk("R1 in empty after reset", 32'(in_empty), 32'd1);
    endtask

    task automatic t_in_narrow();
        do_reset(1'b0);
        in_read(zx(0) & '0, "R8 read of empty inbound keeps zero");
        for (int s = 1; s <= 3; s++) in_write(s);
        settle();
        chk("R2 not empty after writes", 32'(in_empty), 32'd0);
        in_read(zx(1), "R2 first nibble");
        repeat (3) @(negedge rd_clk);
        chk("R9 rd_data holds", 32'(in_rd), 32'(zx(1)));
        in_read(zx(2), "R2 second nibble");
        in_read(zx(3), "R2 third nibble");
        chk("R2 empty after drain", 32'(in_empty), 32'd1);
        in_read(zx(3), "R8 read while empty ignored");
    endtask

    task automatic t_in_wide();
        do_reset(1'b1);
        for (int s = 1; s <= 6; s++) in_write(s);
        settle();
        in_read(pk(2, 1), "R3 pack pair 1");
        in_read(pk(4, 3), "R3 pack pair 2");
        in_read(pk(6, 5), "R3 pack pair 3");
        in_write(7);
        settle();
        chk("R3 lone nibble not readable", 32'(in_empty), 32'd1);
    endtask

    task automatic t_in_full();
        do_reset(1'b0);
        for (int s = 1; s <= 4; s++) in_write(s);
        chk("R6 narrow full at depth", 32'(in_full), 32'd1);
        in_write(5);
        settle();
        for (int s = 1; s <= 4; s++) in_read(zx(s), "R7 narrow contents intact");
        chk("R7 dropped write not stored", 32'(in_empty), 32'd1);

        do_reset(1'b1);
        for (int s = 1; s <= 8; s++) in_write(s);
        chk("R6 wide not full without staged nibble", 32'(in_full), 32'd0);
        in_write(9);
        chk("R6 wide full with staged nibble", 32'(in_full), 32'd1);
        in_write(10);
        chk("R7 still full after dropped write", 32'(in_full), 32'd1);
        settle();
        for (int s = 1; s <= 4; s++) in_read(pk(2 * s, 2 * s - 1), "R7 wide contents intact");
        settle();
        chk("R6 full clears after drain", 32'(in_full), 32'd0);
        in_write(11);
        settle();
        in_read(pk(11, 9), "R7 staged nibble kept, dropped one lost");
    endtask

    task automatic t_ob_narrow();
        do_reset(1'b0);
        for (int s = 1; s <= 3; s++) ob_write(s);
        settle();
        for (int s = 1; s <= 3; s++) ob_read(lo_of(s), "R4 low nibble only");
        chk("R4 empty after drain", 32'(ob_empty), 32'd1);
    endtask

    task automatic t_ob_wide();
        do_reset(1'b1);
        ob_write(4);
        ob_write(5);
        settle();
        ob_read(lo_of(4), "R5 first half low");
        chk("R5 not empty mid entry", 32'(ob_empty), 32'd0);
        ob_read(hi_of(4), "R5 second half high");
        ob_read(lo_of(5), "R5 next entry low");
        ob_read(hi_of(5), "R5 next entry high");
        chk("R5 empty after both halves", 32'(ob_empty), 32'd1);
    endtask

    task automatic t_ob_full();
        do_reset(1'b1);
        for (int s = 1; s <= 4; s++) ob_write(s);
        chk("R6 outbound full at depth", 32'(ob_full), 32'd1);
        ob_write(5);
        settle();
        for (int s = 1; s <= 4; s++) begin
            ob_read(lo_of(s), "R7 outbound low intact");
            ob_read(hi_of(s), "R7 outbound high intact");
        end
        chk("R7 outbound empty after drain", 32'(ob_empty), 32'd1);
        ob_read(hi_of(4), "R8 outbound read while empty ignored");
        ob_write(6);
        settle();
        ob_read(lo_of(6), "R7 dropped outbound write lost");
    endtask

    task automatic t_reset_mid();
        do_reset(1'b1);
        in_write(1);
        in_write(2);
        in_write(3);
        ob_write(1);
        ob_write(2);
        settle();
        ob_read(lo_of(1), "R5 low before reset");
        do_reset(1'b1);
        chk("R1 in empty after mid reset", 32'(in_empty), 32'd1);
        chk("R1 ob empty after mid reset", 32'(ob_empty), 32'd1);
        in_write(20);
        in_write(21);
        settle();
        in_read(pk(21, 20), "R1 staged nibble discarded");
        ob_write(7);
        settle();
        ob_read(lo_of(7), "R1 unpack state discarded");
    endtask

    initial begin
        t_reset_state();
        t_in_narrow();
        t_in_wide();
        t_in_full();
        t_ob_narrow();
        t_ob_wide();
        t_ob_full();
        t_reset_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wr_clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (R1-related run control): got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule